// File: doc/BRIEF.md
# CRC-Protected Register Access Engine

This block is the transaction layer behind a byte-level I2C target. A bus front end hands it decoded events: a start or repeated-start pulse, a stop pulse, each received byte, and a pulse each time it has shifted a byte out to the host. The engine decides whether the frame is addressed to it. It reads a command byte that carries a register offset and a burst length. For writes, it commits the burst to a register file only when the frame checks out. For reads, it serves the burst with a CRC byte appended.

Every frame is protected by CRC-8 with polynomial 0x07. The CRC is computed MSB first, starts at zero and has no output inversion. It runs over three things: the 8-bit address byte (7-bit device address shifted up, with the direction bit in bit 0), then the command byte, then the data. Burst addresses advance modulo 64.

The register file sees one flattened address vector, with one offset per burst lane, and a flattened read-data vector for those lanes. Writes arrive as a single-cycle write strobe with lane enables.

Top module: `crc_reg_access`

## Requirements
- R1: The command byte uses bits [5:0] for the start offset and bits [7:6] for the burst length. The length codes are 00 = 1 byte, 01 = 2, 10 = 3 and 11 = 4.
- R2: The CRC is CRC-8, polynomial 0x07, MSB first, initial value 0x00, no final XOR. It covers the address byte, then the command byte, then the data bytes. A write frame must use the address byte with bit 0 = 0. A write whose CRC was computed with bit 0 = 1 is rejected.
- R3: A write frame has this form: start, address byte (bit 0 = 0), command, N data bytes, CRC byte, one dummy byte of any value, stop. Such a frame with a matching CRC produces a single-cycle `rf_we` in the cycle after the stop. `rf_wbe` has its low N bits set, and all N bytes are committed together.
- R4: A write is discarded and `crc_error` is set in these cases: the CRC mismatches; the stop arrives after a number of post-command bytes other than N+2; or a new start arrives after at least one post-command byte. `crc_error` stays set until reset.
- R5: Burst lane i addresses offset+i modulo 64, for reads and for writes.
- R6: A read frame has this form: start, address byte (bit 0 = 0), command, repeated start, address byte (bit 0 = 1), then bytes clocked out. The read data is captured in the cycle the bit-0 = 1 address byte is accepted. Later register changes do not alter the bytes returned.
- R7: A read returns the N data bytes and then the CRC over the read address byte (bit 0 = 1), the command and the data.
- R8: Bytes clocked out after the CRC byte read as 0xFF and leave the CRC state unchanged. Ending a read frame never sets `crc_error`.
- R9: A frame whose address byte bits [7:1] differ from `DEV_ADDR` is ignored. Nothing is committed, `crc_error` is unchanged, `selected` stays low and `tx_byte` reads 0xFF.
- R10: After reset, `crc_error` = 0, `rf_we` = 0, `selected` = 0 and `tx_byte` = 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_start | input | 1 | Pulse: start or repeated start seen on the bus |
| bus_stop | input | 1 | Pulse: stop seen on the bus |
| rx_valid | input | 1 | Pulse: `rx_byte` holds a byte received from the host |
| rx_byte | input | 8 | Received byte |
| tx_take | input | 1 | Pulse: the front end has shifted out `tx_byte` |
| tx_byte | output | 8 | Next byte to return to the host |
| selected | output | 1 | Frame is addressed here (command, write data or read phase) |
| rf_addr | output | 24 | Four 6-bit lane offsets, lane i in bits [6i+5:6i] |
| rf_rdata | input | 32 | Register contents for each lane, lane i in bits [8i+7:8i] |
| rf_we | output | 1 | Single-cycle write commit strobe |
| rf_wbe | output | 4 | Lane enables for the commit |
| rf_wdata | output | 32 | Write data per lane, lane i in bits [8i+7:8i] |
| crc_error | output | 1 | Sticky flag: a write frame was rejected |

## Verification
The bench builds each frame byte by byte. It computes the CRC itself, then varies one property of the frame at a time. The variations are: a corrupted CRC, a CRC computed with the read direction bit, a missing dummy byte, an extra trailing byte, and a new start cutting into the data. A design that counted bytes loosely would commit a truncated or padded write. A design that dropped the address byte from the CRC, or used the wrong direction bit, would accept or reject the wrong frames.

Bursts are placed across offset 63 so that a missing modulo-64 wrap writes or reads the wrong registers. A register is changed after the read address byte has been taken, which exposes a design that reads live data instead of a snapshot. Extra bytes are clocked past the CRC to catch a design that keeps returning data or keeps advancing its CRC.

// File: rtl/crc_acc_pkg.sv
// Shared constants and state encoding for the CRC-protected register engine.
package crc_acc_pkg;
    localparam int unsigned MAX_BURST = 4;                     // data bytes per access
    localparam int unsigned OFS_W     = 6;                     // register offset width
    localparam int unsigned LEN_W     = $clog2(MAX_BURST);     // length code width
    localparam int unsigned CNT_W     = $clog2(MAX_BURST + 4); // byte counter width
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    typedef enum logic [2:0] {
        S_IDLE, S_ADDR, S_CMD, S_WDATA, S_RADDR, S_RDATA, S_SKIP
    } fsm_t;
endpackage

// File: rtl/crc8_byte.sv
// crc8_byte: combinational one-byte CRC-8 update, MSB first.
// Assumes: the caller holds the running remainder; no init or final XOR here.
module crc8_byte #(
    parameter logic [7:0] POLY = 8'h07
) (
    input  logic [7:0] crc_in,
    input  logic [7:0] data_in,
    output logic [7:0] crc_out
);
    logic [7:0] stage [9];

    assign stage[0] = crc_in ^ data_in;

    // One shift-and-reduce step per bit, MSB first.
    for (genvar b = 0; b < 8; b++) begin : g_bit
        assign stage[b+1] = stage[b][7] ? ((stage[b] << 1) ^ POLY) : (stage[b] << 1);
    end

    assign crc_out = stage[8];
endmodule

// File: rtl/wr_collect.sv
// wr_collect: gathers a write burst, runs its CRC and judges the frame.
// Assumes: addr_v, cmd_v and data_v never coincide with clear; nbytes is 1..MAX_BURST.
module wr_collect import crc_acc_pkg::*; (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   clear,
    input  logic                   addr_v,
    input  logic                   cmd_v,
    input  logic                   data_v,
    input  logic [7:0]             rx_byte,
    input  logic [CNT_W-1:0]       nbytes,
    output logic                   frame_good,
    output logic                   no_payload,
    output logic [MAX_BURST*8-1:0] wdata
);
    logic [7:0]       crc_q, crc_seed, crc_run;
    logic [CNT_W-1:0] cnt;
    logic             match;
    logic [7:0]       wbuf [MAX_BURST];

    crc8_byte u_seed (.crc_in(8'h00), .data_in(rx_byte), .crc_out(crc_seed));
    crc8_byte u_run  (.crc_in(crc_q), .data_in(rx_byte), .crc_out(crc_run));

    // Running CRC, post-command byte count and CRC-match flag.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            crc_q <= 8'h00;
            cnt   <= '0;
            match <= 1'b0;
        end else if (addr_v) begin
            crc_q <= crc_seed;
        end else if (cmd_v) begin
            crc_q <= crc_run;
        end else if (data_v) begin
            if (cnt < nbytes)
                crc_q <= crc_run;
            else if (cnt == nbytes)
                match <= (rx_byte == crc_q);
            if (cnt != CNT_MAX)
                cnt <= cnt + 1'b1;
        end
    end

    // Data lane capture; the buffer survives clear so a commit can read it.
    always_ff @(posedge clk) begin
        for (int i = 0; i < int'(MAX_BURST); i++) begin
            if (!rst_n)
                wbuf[i] <= 8'h00;
            else if (data_v && (cnt < nbytes) && (cnt == CNT_W'(i)))
                wbuf[i] <= rx_byte;
        end
    end

    assign frame_good = match && (cnt == nbytes + CNT_W'(2));
    assign no_payload = (cnt == '0);

    for (genvar i = 0; i < int'(MAX_BURST); i++) begin : g_wd
        assign wdata[i*8 +: 8] = wbuf[i];
    end

    // Once saturated, the count cannot roll back and fake a valid length.
    assert_cnt_sat_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (data_v && !clear && cnt == CNT_MAX) |=> (cnt == CNT_MAX));
endmodule

// File: rtl/rd_server.sv
// rd_server: snapshots a read burst and returns data, then CRC, then 0xFF.
// Assumes: load and take never coincide with clear; nbytes is 1..MAX_BURST.
module rd_server import crc_acc_pkg::*; (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   clear,
    input  logic                   load,
    input  logic [7:0]             addr_byte,
    input  logic [7:0]             cmd_byte,
    input  logic [CNT_W-1:0]       nbytes,
    input  logic [MAX_BURST*8-1:0] snap,
    input  logic                   take,
    output logic [7:0]             tx_byte
);
    logic [7:0]       crc_q, crc_a, crc_ac, crc_tx, cur_data;
    logic [CNT_W-1:0] idx;
    logic [7:0]       rbuf [MAX_BURST];

    crc8_byte u_addr (.crc_in(8'h00), .data_in(addr_byte), .crc_out(crc_a));
    crc8_byte u_cmd  (.crc_in(crc_a), .data_in(cmd_byte),  .crc_out(crc_ac));
    crc8_byte u_tx   (.crc_in(crc_q), .data_in(cur_data),  .crc_out(crc_tx));

    // Select the buffered byte at the current index.
    always_comb begin
        cur_data = 8'h00;
        for (int i = 0; i < int'(MAX_BURST); i++)
            if (idx == CNT_W'(i)) cur_data = rbuf[i];
    end

    // Index and CRC advance as bytes go out; stop advancing past the CRC byte.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            idx   <= CNT_MAX;
            crc_q <= 8'h00;
        end else if (load) begin
            idx   <= '0;
            crc_q <= crc_ac;
        end else if (take) begin
            if (idx < nbytes)
                crc_q <= crc_tx;
            if (idx <= nbytes)
                idx <= idx + 1'b1;
        end
    end

    // Snapshot of the burst at the start of the read phase.
    always_ff @(posedge clk) begin
        for (int i = 0; i < int'(MAX_BURST); i++) begin
            if (!rst_n)
                rbuf[i] <= 8'h00;
            else if (load)
                rbuf[i] <= snap[i*8 +: 8];
        end
    end

    assign tx_byte = (idx < nbytes)  ? cur_data :
                     (idx == nbytes) ? crc_q    : 8'hFF;

    // Over-read bytes must not disturb the CRC state.
    assert_overread_crc_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !clear && !load && idx > nbytes) |=> $stable(crc_q));
endmodule

// File: rtl/crc_reg_access.sv
// crc_reg_access: frame sequencer for CRC-protected register reads and writes.
// Assumes: front end gives one-cycle event pulses; start and stop never share a cycle
// with rx_valid (stop wins if they do). Register file applies rf_we in one cycle.
module crc_reg_access import crc_acc_pkg::*; #(
    parameter logic [6:0] DEV_ADDR = 7'h2A
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       bus_start,
    input  logic                       bus_stop,
    input  logic                       rx_valid,
    input  logic [7:0]                 rx_byte,
    input  logic                       tx_take,
    output logic [7:0]                 tx_byte,
    output logic                       selected,
    output logic [MAX_BURST*OFS_W-1:0] rf_addr,
    input  logic [MAX_BURST*8-1:0]     rf_rdata,
    output logic                       rf_we,
    output logic [MAX_BURST-1:0]       rf_wbe,
    output logic [MAX_BURST*8-1:0]     rf_wdata,
    output logic                       crc_error
);
    fsm_t             state, state_nx;
    logic [7:0]       cmd_q;
    logic [CNT_W-1:0] nbytes;
    logic             ev_ok, addr_hit, frame_good, no_payload;
    logic             wr_addr_v, cmd_v, data_v, rd_load, rd_take, unit_clear;
    logic             commit, bad_end;
    logic [MAX_BURST-1:0] wbe_nx;

    assign ev_ok      = rx_valid && !bus_start && !bus_stop;
    assign addr_hit   = (rx_byte[7:1] == DEV_ADDR);
    assign wr_addr_v  = ev_ok && state == S_ADDR  && addr_hit && !rx_byte[0];
    assign cmd_v      = ev_ok && state == S_CMD;
    assign data_v     = ev_ok && state == S_WDATA;
    assign rd_load    = ev_ok && state == S_RADDR && addr_hit && rx_byte[0];
    assign rd_take    = tx_take && !bus_start && !bus_stop && state == S_RDATA;
    assign unit_clear = bus_start || bus_stop;
    assign nbytes     = CNT_W'(cmd_q[OFS_W +: LEN_W]) + CNT_W'(1);
    assign commit     = state == S_WDATA && bus_stop && frame_good;
    assign bad_end    = state == S_WDATA &&
                        ((bus_stop && !frame_good) || (bus_start && !bus_stop && !no_payload));
    assign selected   = (state == S_CMD) || (state == S_WDATA) || (state == S_RDATA);

    wr_collect u_wr (
        .clk(clk), .rst_n(rst_n), .clear(unit_clear), .addr_v(wr_addr_v),
        .cmd_v(cmd_v), .data_v(data_v), .rx_byte(rx_byte), .nbytes(nbytes),
        .frame_good(frame_good), .no_payload(no_payload), .wdata(rf_wdata)
    );

    rd_server u_rd (
        .clk(clk), .rst_n(rst_n), .clear(unit_clear), .load(rd_load),
        .addr_byte(rx_byte), .cmd_byte(cmd_q), .nbytes(nbytes),
        .snap(rf_rdata), .take(rd_take), .tx_byte(tx_byte)
    );

    // Lane offsets wrap modulo 2**OFS_W through natural truncation.
    for (genvar i = 0; i < int'(MAX_BURST); i++) begin : g_lane
        assign rf_addr[i*OFS_W +: OFS_W] = cmd_q[OFS_W-1:0] + OFS_W'(i);
        assign wbe_nx[i] = (CNT_W'(i) < nbytes);
    end

    // Next frame state from bus events and the byte just received.
    always_comb begin
        state_nx = state;
        if (bus_stop)
            state_nx = S_IDLE;
        else if (bus_start)
            state_nx = (state == S_WDATA && no_payload) ? S_RADDR : S_ADDR;
        else if (rx_valid) begin
            case (state)
                S_ADDR:  state_nx = (addr_hit && !rx_byte[0]) ? S_CMD : S_SKIP;
                S_CMD:   state_nx = S_WDATA;
                S_RADDR: state_nx = (addr_hit && rx_byte[0]) ? S_RDATA : S_SKIP;
                default: state_nx = state;
            endcase
        end
    end

    // Frame state register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    // Command byte holding register.
    always_ff @(posedge clk) begin
        if (!rst_n)     cmd_q <= 8'h00;
        else if (cmd_v) cmd_q <= rx_byte;
    end

    // Commit strobe and lane enables, one cycle after an accepted stop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rf_we  <= 1'b0;
            rf_wbe <= '0;
        end else begin
            rf_we  <= commit;
            rf_wbe <= commit ? wbe_nx : '0;
        end
    end

    // Sticky rejection flag.
    always_ff @(posedge clk) begin
        if (!rst_n)       crc_error <= 1'b0;
        else if (bad_end) crc_error <= 1'b1;
    end

    assert_we_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we |=> !rf_we);
    assert_we_lane0_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we |-> rf_wbe[0]);
    assert_err_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
        crc_error |=> crc_error);
    assert_commit_clean_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we |-> $stable(crc_error));
endmodule

// File: tb/sim_crc_reg_access.sv
module sim_crc_reg_access;
    localparam logic [6:0] DEV = 7'h2A;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_start = 1'b0, bus_stop = 1'b0, rx_valid = 1'b0, tx_take = 1'b0;
    logic [7:0]  rx_byte = 8'h00;
    logic [7:0]  tx_byte;
    logic        selected, rf_we, crc_error;
    logic [23:0] rf_addr;
    logic [31:0] rf_rdata, rf_wdata;
    logic [3:0]  rf_wbe;
    logic        poke_en = 1'b0;
    logic [5:0]  poke_a = '0;
    logic [7:0]  poke_d = '0;
    logic [7:0]  mem [64];
    int          checks = 0, errors = 0;

    always #2 clk = ~clk;

    crc_reg_access #(.DEV_ADDR(DEV)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_start(bus_start), .bus_stop(bus_stop),
        .rx_valid(rx_valid), .rx_byte(rx_byte), .tx_take(tx_take), .tx_byte(tx_byte),
        .selected(selected), .rf_addr(rf_addr), .rf_rdata(rf_rdata), .rf_we(rf_we),
        .rf_wbe(rf_wbe), .rf_wdata(rf_wdata), .crc_error(crc_error)
    );

    // Register file model: initialised during reset, poked by tests, written by commits.
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 64; i++) mem[i] <= 8'(i * 3 + 1);
        end else begin
            if (poke_en) mem[poke_a] <= poke_d;
            if (rf_we)
                for (int i = 0; i < 4; i++)
                    if (rf_wbe[i]) mem[rf_addr[i*6 +: 6]] <= rf_wdata[i*8 +: 8];
        end
    end

    for (genvar i = 0; i < 4; i++) begin : g_rd
        assign rf_rdata[i*8 +: 8] = mem[rf_addr[i*6 +: 6]];
    end

    function automatic logic [7:0] crc_upd(input logic [7:0] c, input logic [7:0] d);
        logic [7:0] r;
        r = c ^ d;
        for (int b = 0; b < 8; b++) r = r[7] ? ((r << 1) ^ 8'h07) : (r << 1);
        return r;
    endfunction

    function automatic logic [7:0] init_val(input int a);
        return 8'(a * 3 + 1);
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic reset_dut();
        rst_n = 1'b0;
        idle(3);
        rst_n = 1'b1;
        idle(1);
    endtask

    task automatic pulse_start();
        bus_start = 1'b1; @(negedge clk); bus_start = 1'b0;
    endtask

    task automatic pulse_stop();
        bus_stop = 1'b1; @(negedge clk); bus_stop = 1'b0;
    endtask

    task automatic put_byte(input logic [7:0] b);
        rx_valid = 1'b1; rx_byte = b; @(negedge clk); rx_valid = 1'b0;
    endtask

    task automatic get_byte(output logic [7:0] b);
        b = tx_byte; tx_take = 1'b1; @(negedge clk); tx_take = 1'b0;
    endtask

    // mode: 0 good, 1 corrupt CRC, 2 CRC with read bit, 3 no dummy, 4 extra byte
    task automatic do_write(input logic [6:0] dev, input logic [7:0] cmd,
                            input logic [31:0] dat, input int mode);
        int n = int'(cmd[7:6]) + 1;
        logic [7:0] c;
        c = crc_upd(8'h00, {dev, (mode == 2)});
        c = crc_upd(c, cmd);
        for (int i = 0; i < n; i++) c = crc_upd(c, dat[8*i +: 8]);
        if (mode == 1) c = c ^ 8'h01;
        pulse_start();
        put_byte({dev, 1'b0});
        put_byte(cmd);
        for (int i = 0; i < n; i++) put_byte(dat[8*i +: 8]);
        put_byte(c);
        if (mode != 3) put_byte(8'h5A);
        if (mode == 4) put_byte(8'h00);
        pulse_stop();
        idle(2);
    endtask

    task automatic do_read(input logic [7:0] cmd, input int nread, input logic poke,
                           input logic [7:0] pval, output logic [47:0] got);
        got = '0;
        pulse_start();
        put_byte({DEV, 1'b0});
        put_byte(cmd);
        pulse_start();
        put_byte({DEV, 1'b1});
        if (poke) begin
            poke_en = 1'b1; poke_a = cmd[5:0]; poke_d = pval;
            @(negedge clk); poke_en = 1'b0;
        end
        for (int i = 0; i < nread; i++) begin
            logic [7:0] b;
            get_byte(b);
            got[8*i +: 8] = b;
        end
        pulse_stop();
        idle(2);
    endtask

    task automatic t_reset();
        reset_dut();
        chk("R10 crc_error after reset", 32'(crc_error), 32'd0);
        chk("R10 rf_we after reset", 32'(rf_we), 32'd0);
        chk("R10 selected after reset", 32'(selected), 32'd0);
        chk("R10 tx_byte after reset", 32'(tx_byte), 32'hFF);
    endtask

    task automatic t_write_single();
        reset_dut();
        do_write(DEV, 8'h05, 32'h000000A5, 0);
        chk("R3 single byte committed", 32'(mem[5]), 32'hA5);
        chk("R1 length code 00 writes one byte", 32'(mem[6]), 32'(init_val(6)));
        chk("R3 good write leaves no error", 32'(crc_error), 32'd0);
    endtask

    task automatic t_write_wrap();
        reset_dut();
        do_write(DEV, 8'hFE, 32'h44332211, 0);
        chk("R5 lane0 at 62", 32'(mem[62]), 32'h11);
        chk("R5 lane1 at 63", 32'(mem[63]), 32'h22);
        chk("R5 lane2 wraps to 0", 32'(mem[0]), 32'h33);
        chk("R5 lane3 wraps to 1", 32'(mem[1]), 32'h44);
        chk("R1 four-byte burst stops at 1", 32'(mem[2]), 32'(init_val(2)));
    endtask

    task automatic t_read_wrap();
        logic [47:0] g;
        logic [7:0]  c;
        reset_dut();
        do_read(8'h7F, 4, 1'b0, 8'h00, g);
        c = crc_upd(crc_upd(crc_upd(crc_upd(8'h00, {DEV, 1'b1}), 8'h7F), init_val(63)), init_val(0));
        chk("R5 read lane0 at 63", 32'(g[7:0]), 32'(init_val(63)));
        chk("R5 read lane1 wraps to 0", 32'(g[15:8]), 32'(init_val(0)));
        chk("R7 read CRC byte", 32'(g[23:16]), 32'(c));
        chk("R8 over-read returns FF", 32'(g[31:24]), 32'hFF);
        chk("R8 read leaves no error", 32'(crc_error), 32'd0);
    endtask

    task automatic t_read_three();
        logic [47:0] g;
        logic [7:0]  c;
        reset_dut();
        do_read(8'hA0, 5, 1'b0, 8'h00, g);
        c = crc_upd(crc_upd(8'h00, {DEV, 1'b1}), 8'hA0);
        for (int i = 0; i < 3; i++) c = crc_upd(c, init_val(32 + i));
        chk("R1 code 10 gives three data bytes", {8'h0, g[23:0]},
            {8'h0, init_val(34), init_val(33), init_val(32)});
        chk("R7 CRC after three bytes", 32'(g[31:24]), 32'(c));
        chk("R8 second over-read byte FF", 32'(g[39:32]), 32'hFF);
    endtask

    task automatic t_snapshot();
        logic [47:0] g;
        logic [7:0]  c;
        reset_dut();
        do_read(8'h05, 2, 1'b1, 8'h77, g);
        c = crc_upd(crc_upd(crc_upd(8'h00, {DEV, 1'b1}), 8'h05), init_val(5));
        chk("R6 data captured at read address", 32'(g[7:0]), 32'(init_val(5)));
        chk("R7 CRC over captured data", 32'(g[15:8]), 32'(c));
        do_read(8'h05, 1, 1'b0, 8'h00, g);
        chk("R6 next frame sees new value", 32'(g[7:0]), 32'h77);
    endtask

    task automatic t_bad_crc();
        reset_dut();
        do_write(DEV, 8'h10, 32'h000000C3, 1);
        chk("R4 corrupt CRC not committed", 32'(mem[16]), 32'(init_val(16)));
        chk("R4 corrupt CRC sets flag", 32'(crc_error), 32'd1);
        do_write(DEV, 8'h11, 32'h00000099, 0);
        chk("R3 later good write commits", 32'(mem[17]), 32'h99);
        chk("R4 flag stays set", 32'(crc_error), 32'd1);
    endtask

    task automatic t_length_errors();
        reset_dut();
        do_write(DEV, 8'h50, 32'h0000BBAA, 3);
        chk("R4 missing dummy discarded", 32'(mem[16]), 32'(init_val(16)));
        chk("R4 missing dummy flagged", 32'(crc_error), 32'd1);
        reset_dut();
        do_write(DEV, 8'h50, 32'h0000BBAA, 4);
        chk("R4 extra byte discarded", 32'(mem[17]), 32'(init_val(17)));
        chk("R4 extra byte flagged", 32'(crc_error), 32'd1);
    endtask

    task automatic t_rw_bit();
        reset_dut();
        do_write(DEV, 8'h08, 32'h000000E1, 2);
        chk("R2 read-bit CRC rejected on write", 32'(mem[8]), 32'(init_val(8)));
        chk("R2 read-bit CRC flagged", 32'(crc_error), 32'd1);
    endtask

    task automatic t_mid_start();
        reset_dut();
        pulse_start();
        put_byte({DEV, 1'b0});
        put_byte(8'hC8);
        put_byte(8'hD1);
        put_byte(8'hD2);
        do_write(DEV, 8'h0A, 32'h000000EE, 0);
        chk("R4 aborted burst not committed", 32'(mem[8]), 32'(init_val(8)));
        chk("R4 abort flagged", 32'(crc_error), 32'd1);
        chk("R3 restarted frame commits", 32'(mem[10]), 32'hEE);
    endtask

    task automatic t_wrong_dev();
        reset_dut();
        do_write(7'h2B, 8'h05, 32'h000000A5, 0);
        chk("R9 foreign write ignored", 32'(mem[5]), 32'(init_val(5)));
        chk("R9 foreign write no flag", 32'(crc_error), 32'd0);
        pulse_start();
        put_byte({7'h2B, 1'b0});
        put_byte(8'h05);
        chk("R9 not selected", 32'(selected), 32'd0);
        pulse_start();
        put_byte({7'h2B, 1'b1});
        chk("R9 tx idle FF", 32'(tx_byte), 32'hFF);
        pulse_stop();
        idle(2);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired, R10 run did not finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_write_single();
        t_write_wrap();
        t_read_wrap();
        t_read_three();
        t_snapshot();
        t_bad_crc();
        t_length_errors();
        t_rw_bit();
        t_mid_start();
        t_wrong_dev();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule